// File: doc/BRIEF.md
# DDR3 Device Command and Read Latency Model

This block models the command front end of a DDR3 DRAM as seen from the device side. On every rising clock it samples the chip select, the three active-low command strobes, the bank address and the address bus. It decodes the sample into one of six command classes and keeps an open/closed flag and an open row for each of the eight banks. Misuse, such as accessing a closed bank or activating an open one, raises a one-cycle error flag.

Mode register set commands program the CAS latency, the additive latency, the burst length mode and the burst ordering. The bank address of the command selects which mode register is written. For every read to an open bank the block schedules a data window. The window starts AL+CL clocks after the command and lasts two clocks for a 4-beat chopped burst or four clocks for a full 8-beat burst. Chopping is set per command by address bit 12 when the burst mode allows it.

A memory controller model or a bench uses this block as a protocol oracle. Data, strobes, termination and refresh are not modelled.

Top module: `ddr3_cmd_model`

## Requirements
- R1: When `cs_ni` is sampled high, the sample is a no-operation: `cmd_o` reads 0 in the next cycle, and no bank state, latency setting or read window changes.
- R2: With `cs_ni` low, {ras,cas,we} = 011 decodes to activate (`cmd_o`=1), 101 to read (2), 100 to write (3), 010 to precharge (4) and 000 to mode register set (5). 111, 001 and 110 decode to no-operation (0). `cmd_o` and `err_o` are registered and appear in the cycle after the sampling edge.
- R3: An activate to a closed bank marks bank `ba_i` open and stores `addr_i` as its row. A read or write to an open bank loads that bank's row into `acc_row_o`.
- R4: A precharge with `addr_i[10]` low closes bank `ba_i`, and with `addr_i[10]` high it closes all banks. A read or write with `addr_i[10]` high closes its bank after the access.
- R5: `err_o` pulses for a read or write to a closed bank and for an activate to an open bank. An activate to an open bank keeps the existing row. A read to a closed bank schedules no data window.
- R6: A mode register set with `ba_i`=0 writes register 0. `addr_i[6:4]` holds CL-4, so values 2..6 give CL 6..10. `addr_i[3]` sets interleaved ordering when 1. `addr_i[1:0]` selects the burst mode: 00 fixed 8 beats, 01 chop chosen per command, 10 fixed 4 beats. A write with an out-of-range CL field or burst mode 11 is ignored entirely.
- R7: A mode register set with `ba_i`=1 selects the additive latency from `addr_i[4:3]`: 00 gives 0, 01 gives CL-1, 10 gives CL-2, and 11 is ignored. `al_o` follows later CL changes. A mode register set with any other bank value changes nothing.
- R8: For a read to an open bank sampled at edge n, `rd_start_o` is high for the one cycle after edge n+AL+CL. `rd_valid_o` is high for the cycles following edges n+AL+CL onward, covering the full window. All read latencies from 6 up to 19 are supported.
- R9: The window lasts 4 cycles with `rd_beats_o`=8, or 2 cycles with `rd_beats_o`=4 when the burst is chopped. A burst is chopped in fixed-4 mode, or in per-command mode when `addr_i[12]` is low. Fixed-8 mode ignores `addr_i[12]`.
- R10: The asynchronous reset `rst_ni` closes all banks, clears pending windows and the outputs, and sets CL=6, AL=0, fixed 8-beat bursts and sequential ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank address / mode register select |
| addr_i | input | 15 | Row, column or mode op-code |
| cmd_o | output | 3 | Decoded command of the previous sample |
| err_o | output | 1 | Bank state protocol error pulse |
| bank_open_o | output | 8 | Open flag per bank |
| acc_row_o | output | 15 | Row of the bank hit by the last read or write |
| cl_o | output | 5 | Programmed CAS latency |
| al_o | output | 5 | Effective additive latency |
| burst_il_o | output | 1 | Interleaved burst ordering selected |
| rd_start_o | output | 1 | First cycle of a read data window |
| rd_valid_o | output | 1 | Read data window active |
| rd_beats_o | output | 4 | Beats in the current window (4 or 8) |

## Verification
The bench goes after the latency extremes: the minimum read latency of 6 and the maximum of 19, with AL=CL-1 and CL=10. A pipeline one slot short or an off-by-one index would move the start strobe or drop the window entirely. It checks that AL follows a later CL change, which a design that latches AL as a number would miss. It also checks that rejected mode writes leave every field untouched, which would catch partial updates. On the bank side, it checks that a repeated activate does not overwrite the stored row, that auto-precharge closes only the accessed bank, and that an erroring read produces no window. A design that still launched the timer on that read would raise a phantom data window.

// File: rtl/ddr3_cmd_pkg.sv
`timescale 1ns/1ps
package ddr3_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    BURST_FIX8 = 2'b00,
    BURST_OTF  = 2'b01,
    BURST_FIX4 = 2'b10
  } burst_mode_e;
endpackage

// File: rtl/ddr3_cmd_decode.sv
`timescale 1ns/1ps
module ddr3_cmd_decode
  import ddr3_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP; // refresh, calibration, nop
      endcase
    end
  end
endmodule

// File: rtl/ddr3_mode_regs.sv
`timescale 1ns/1ps
module ddr3_mode_regs
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int LAT_W  = 5,
  parameter int CL_MIN = 6,
  parameter int CL_MAX = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [6:0]        op_i,
  output logic [LAT_W-1:0]  cl_o,
  output logic [LAT_W-1:0]  al_o,
  output burst_mode_e       bl_mode_o,
  output logic              burst_il_o
);
  localparam int CL_OFS = 4;

  logic [LAT_W-1:0] cl_q, cl_new;
  logic [1:0]       al_sel_q;
  burst_mode_e      bl_q;
  logic             il_q;
  logic             mr0_ok;

  assign cl_new = LAT_W'(op_i[6:4]) + LAT_W'(CL_OFS);
  assign mr0_ok = (cl_new >= LAT_W'(CL_MIN)) && (cl_new <= LAT_W'(CL_MAX))
                  && (op_i[1:0] != 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_q     <= LAT_W'(CL_MIN);
      al_sel_q <= 2'b00;
      bl_q     <= BURST_FIX8;
      il_q     <= 1'b0;
    end else if (cmd_i == CMD_MRS) begin
      if (ba_i == BANK_W'(0)) begin
        if (mr0_ok) begin
          cl_q <= cl_new;
          il_q <= op_i[3];
          bl_q <= burst_mode_e'(op_i[1:0]);
        end
      end else if (ba_i == BANK_W'(1)) begin
        if (op_i[4:3] != 2'b11) al_sel_q <= op_i[4:3];
      end
    end
  end

  always_comb begin
    unique case (al_sel_q)
      2'b01:   al_o = cl_q - LAT_W'(1);
      2'b10:   al_o = cl_q - LAT_W'(2);
      default: al_o = '0;
    endcase
  end

  assign cl_o       = cl_q;
  assign bl_mode_o  = bl_q;
  assign burst_il_o = il_q;
endmodule

// File: rtl/ddr3_bank_table.sv
`timescale 1ns/1ps
module ddr3_bank_table
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 15,
  parameter int AP_BIT = 10
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  cmd_e                               cmd_i,
  input  logic [BANK_W-1:0]                  ba_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  output logic [(1<<BANK_W)-1:0]             open_o,
  output logic [(1<<BANK_W)-1:0][ADDR_W-1:0] rows_o,
  output logic                               hit_o,
  output logic                               err_o
);
  localparam int NBANK = 1 << BANK_W;

  logic is_acc;
  assign is_acc = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign hit_o  = open_o[ba_i];
  assign err_o  = (is_acc && !hit_o) || ((cmd_i == CMD_ACT) && hit_o);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (ba_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        rows_o[b] <= '0;
      end else begin
        unique case (cmd_i)
          CMD_ACT: if (sel && !open_o[b]) begin
            open_o[b] <= 1'b1;
            rows_o[b] <= addr_i;
          end
          CMD_PRE: if (sel || addr_i[AP_BIT]) open_o[b] <= 1'b0;
          CMD_RD, CMD_WR: if (sel && addr_i[AP_BIT]) open_o[b] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr3_rd_timer.sv
`timescale 1ns/1ps
module ddr3_rd_timer #(
  parameter int PIPE_W = 19,
  parameter int LAT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             chop_i,
  input  logic [LAT_W-1:0] rl_i,
  output logic             start_o,
  output logic             valid_o,
  output logic [3:0]       beats_o
);
  // slot k holds a burst whose window opens k+1 edges from now
  logic [PIPE_W-1:0] pend_q, pend_d, chop_q, chop_d;
  logic [2:0]        win_q;
  logic              start_q;
  logic [3:0]        beats_q;

  always_comb begin
    pend_d = pend_q >> 1;
    chop_d = chop_q >> 1;
    if (launch_i && rl_i != '0) begin
      pend_d[rl_i - LAT_W'(1)] = 1'b1;
      chop_d[rl_i - LAT_W'(1)] = chop_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      chop_q  <= '0;
      win_q   <= '0;
      start_q <= 1'b0;
      beats_q <= '0;
    end else begin
      pend_q  <= pend_d;
      chop_q  <= chop_d;
      start_q <= pend_q[0];
      if (pend_q[0]) begin
        win_q   <= chop_q[0] ? 3'd2 : 3'd4;
        beats_q <= chop_q[0] ? 4'd4 : 4'd8;
      end else if (win_q != '0) begin
        win_q <= win_q - 3'd1;
      end
    end
  end

  assign start_o = start_q;
  assign valid_o = (win_q != '0);
  assign beats_o = beats_q;
endmodule

// File: rtl/ddr3_cmd_model.sv
`timescale 1ns/1ps
module ddr3_cmd_model
  import ddr3_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 15,
  parameter int CL_MIN = 6,
  parameter int CL_MAX = 10,
  parameter int LAT_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_ni,
  input  logic                      ras_ni,
  input  logic                      cas_ni,
  input  logic                      we_ni,
  input  logic [BANK_W-1:0]         ba_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [2:0]                cmd_o,
  output logic                      err_o,
  output logic [(1<<BANK_W)-1:0]    bank_open_o,
  output logic [ADDR_W-1:0]         acc_row_o,
  output logic [LAT_W-1:0]          cl_o,
  output logic [LAT_W-1:0]          al_o,
  output logic                      burst_il_o,
  output logic                      rd_start_o,
  output logic                      rd_valid_o,
  output logic [3:0]                rd_beats_o
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int PIPE_W = 2 * CL_MAX - 1;
  localparam int BC_BIT = 12;

  cmd_e                          cmd;
  burst_mode_e                   bl_mode;
  logic [NBANK-1:0][ADDR_W-1:0]  rows;
  logic                          hit, err;
  logic                          chop, launch;
  logic [LAT_W-1:0]              rl;
  logic [2:0]                    cmd_q;
  logic                          err_q;
  logic [ADDR_W-1:0]             row_q;

  ddr3_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cmd_o (cmd)
  );

  ddr3_mode_regs #(
    .BANK_W(BANK_W), .LAT_W(LAT_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX)
  ) u_mr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .ba_i      (ba_i),
    .op_i      (addr_i[6:0]),
    .cl_o      (cl_o),
    .al_o      (al_o),
    .bl_mode_o (bl_mode),
    .burst_il_o(burst_il_o)
  );

  ddr3_bank_table #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_banks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .ba_i  (ba_i),
    .addr_i(addr_i),
    .open_o(bank_open_o),
    .rows_o(rows),
    .hit_o (hit),
    .err_o (err)
  );

  assign chop   = (bl_mode == BURST_FIX4) ||
                  ((bl_mode == BURST_OTF) && !addr_i[BC_BIT]);
  assign launch = (cmd == CMD_RD) && hit;
  assign rl     = al_o + cl_o;

  ddr3_rd_timer #(.PIPE_W(PIPE_W), .LAT_W(LAT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .chop_i  (chop),
    .rl_i    (rl),
    .start_o (rd_start_o),
    .valid_o (rd_valid_o),
    .beats_o (rd_beats_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP;
      err_q <= 1'b0;
      row_q <= '0;
    end else begin
      cmd_q <= cmd;
      err_q <= err;
      if ((cmd == CMD_RD || cmd == CMD_WR) && hit) row_q <= rows[ba_i];
    end
  end

  assign cmd_o     = cmd_q;
  assign err_o     = err_q;
  assign acc_row_o = row_q;
endmodule

// File: rtl/ddr3_cmd_model_chk.sv
`timescale 1ns/1ps
module ddr3_cmd_model_chk #(
  parameter int BANK_W = 3,
  parameter int CL_MIN = 6,
  parameter int CL_MAX = 10,
  parameter int LAT_W  = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   ras_ni,
  input logic                   cas_ni,
  input logic                   we_ni,
  input logic [BANK_W-1:0]      ba_i,
  input logic                   ap_i,
  input logic [2:0]             cmd_o,
  input logic                   err_o,
  input logic [(1<<BANK_W)-1:0] bank_open_o,
  input logic [LAT_W-1:0]       cl_o,
  input logic [LAT_W-1:0]       al_o,
  input logic                   rd_start_o,
  input logic                   rd_valid_o,
  input logic [3:0]             rd_beats_o
);
  logic pin_act, pin_rd, pin_pre, pin_mrs;
  assign pin_act = !cs_ni && !ras_ni &&  cas_ni &&  we_ni;
  assign pin_rd  = !cs_ni &&  ras_ni && !cas_ni &&  we_ni;
  assign pin_pre = !cs_ni && !ras_ni &&  cas_ni && !we_ni;
  assign pin_mrs = !cs_ni && !ras_ni && !cas_ni && !we_ni;

  AST_CS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == 3'd0) && $stable(bank_open_o) && $stable(cl_o) && $stable(al_o)); // R1
  AST_RD_CLOSED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rd && !bank_open_o[ba_i] |=> err_o); // R5
  AST_ACT_OPEN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act && bank_open_o[ba_i] |=> err_o); // R5
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pre && ap_i |=> (bank_open_o == '0)); // R4
  AST_OTHER_MR_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mrs && (ba_i > BANK_W'(1)) |=> $stable(cl_o) && $stable(al_o)); // R7
  AST_CL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_o >= LAT_W'(CL_MIN)) && (cl_o <= LAT_W'(CL_MAX))); // R6
  AST_AL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_o == '0) || (al_o == cl_o - LAT_W'(1)) || (al_o == cl_o - LAT_W'(2))); // R7
  AST_START_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_o |-> rd_valid_o); // R8
  AST_BEATS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_beats_o == 4'd4) || (rd_beats_o == 4'd8)); // R9
endmodule

bind ddr3_cmd_model ddr3_cmd_model_chk #(
  .BANK_W(BANK_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .LAT_W(LAT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .ba_i       (ba_i),
  .ap_i       (addr_i[10]),
  .cmd_o      (cmd_o),
  .err_o      (err_o),
  .bank_open_o(bank_open_o),
  .cl_o       (cl_o),
  .al_o       (al_o),
  .rd_start_o (rd_start_o),
  .rd_valid_o (rd_valid_o),
  .rd_beats_o (rd_beats_o)
);

// File: tb/tb_ddr3_cmd_model.sv
`timescale 1ns/1ps
module tb_ddr3_cmd_model;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic [2:0]  cmd;
  logic        err;
  logic [7:0]  bank_open;
  logic [14:0] acc_row;
  logic [4:0]  cl, al;
  logic        bt_il, rd_start, rd_valid;
  logic [3:0]  rd_beats;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ddr3_cmd_model dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd), .err_o(err),
    .bank_open_o(bank_open), .acc_row_o(acc_row), .cl_o(cl), .al_o(al),
    .burst_il_o(bt_il), .rd_start_o(rd_start), .rd_valid_o(rd_valid),
    .rd_beats_o(rd_beats)
  );

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_MRS = 4'b0000;

  // {cs,ras,cas,we, ba, addr, exp_cmd, exp_err}
  localparam int NVEC = 13;
  localparam logic [25:0] VEC [NVEC] = '{
    {4'b0111, 3'd0, 15'h0000, 3'd0, 1'b0},
    {4'b0011, 3'd0, 15'h0123, 3'd1, 1'b0},
    {4'b0011, 3'd0, 15'h0456, 3'd1, 1'b1},
    {4'b0101, 3'd0, 15'h0010, 3'd2, 1'b0},
    {4'b0101, 3'd1, 15'h0010, 3'd2, 1'b1},
    {4'b0100, 3'd0, 15'h0020, 3'd3, 1'b0},
    {4'b1101, 3'd0, 15'h0010, 3'd0, 1'b0},
    {4'b0010, 3'd0, 15'h0000, 3'd4, 1'b0},
    {4'b0100, 3'd0, 15'h0020, 3'd3, 1'b1},
    {4'b0001, 3'd0, 15'h0000, 3'd0, 1'b0},
    {4'b0011, 3'd7, 15'h7FFF, 3'd1, 1'b0},
    {4'b0010, 3'd3, 15'h0400, 3'd4, 1'b0},
    {4'b0101, 3'd7, 15'h0000, 3'd2, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [2:0] b, input logic [14:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba   = b;
    addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // exp_rl = 0 means no window expected
  task automatic check_read(input int exp_rl, input int exp_dur, input int exp_beats,
                            input string tag);
    int first = 0, vfirst = 0, vcnt = 0, bts = 0;
    for (int k = 1; k <= 26; k++) begin
      @(negedge clk);
      if (rd_start && first == 0) first = k;
      if (rd_valid) begin
        vcnt++;
        if (vfirst == 0) begin vfirst = k; bts = rd_beats; end
      end
    end
    check({tag, " start"}, first, exp_rl);
    check({tag, " window"}, vcnt, exp_dur);
    if (exp_dur != 0) begin
      check({tag, " window open"}, vfirst, exp_rl);
      check({tag, " beats"}, bts, exp_beats);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " cmd"}, cmd, 0);
    check({tag, " err"}, err, 0);
    check({tag, " banks"}, bank_open, 0);
    check({tag, " cl"}, cl, 6);
    check({tag, " al"}, al, 0);
    check({tag, " order"}, bt_il, 0);
    check({tag, " valid"}, rd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check_reset_state("R10 reset");
    rst_n = 1'b1;
    idle(1);

    // vector table: R1 R2 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v][25:22], VEC[v][21:19], VEC[v][18:4]);
      check($sformatf("R2 vec%0d cmd", v), cmd, int'(VEC[v][3:1]));
      check($sformatf("R5 vec%0d err", v), err, int'(VEC[v][0]));
    end
    check("R4 precharge all", bank_open, 0);
    idle(26);

    // R3 / R5: repeated activate keeps the first row
    issue(C_ACT, 3'd2, 15'h0ABC);
    check("R3 bank open", bank_open, 8'h04);
    issue(C_ACT, 3'd2, 15'h1111);
    check("R5 act open err", err, 1);
    issue(C_RD, 3'd2, 15'h1008);
    check("R3 row", acc_row, 15'h0ABC);
    check_read(6, 4, 8, "R8 default");
    issue(C_RD, 3'd2, 15'h0008);
    check_read(6, 4, 8, "R9 fixed8 ignores a12");

    // mode registers
    issue(C_MRS, 3'd0, 15'h0059);            // CL9, interleave, per-command chop
    check("R6 cl", cl, 9);
    check("R6 order", bt_il, 1);
    issue(C_MRS, 3'd1, 15'h0008);            // AL=CL-1
    check("R7 al cl-1", al, 8);
    issue(C_RD, 3'd2, 15'h0000);
    check_read(17, 2, 4, "R9 chop a12 low");
    issue(C_RD, 3'd2, 15'h1000);
    check_read(17, 4, 8, "R8 full a12 high");

    issue(C_MRS, 3'd1, 15'h0010);            // AL=CL-2
    check("R7 al cl-2", al, 7);
    issue(C_MRS, 3'd0, 15'h0062);            // CL10, sequential, fixed chop
    check("R6 cl10", cl, 10);
    check("R6 order seq", bt_il, 0);
    check("R7 al tracks cl", al, 8);
    issue(C_RD, 3'd2, 15'h1000);
    check_read(18, 2, 4, "R9 fixed4");

    issue(C_MRS, 3'd0, 15'h0070);
    check("R6 cl field high ignored", cl, 10);
    issue(C_MRS, 3'd0, 15'h0010);
    check("R6 cl5 ignored", cl, 10);
    issue(C_MRS, 3'd0, 15'h004B);
    check("R6 bl11 ignored cl", cl, 10);
    check("R6 bl11 ignored order", bt_il, 0);
    issue(C_MRS, 3'd1, 15'h0018);
    check("R7 al11 ignored", al, 8);
    issue(C_MRS, 3'd2, 15'h0008);
    check("R7 mr2 no effect al", al, 8);
    check("R7 mr2 no effect cl", cl, 10);
    issue(4'b1000, 3'd1, 15'h0000);
    check("R1 masked mrs", al, 8);

    issue(C_MRS, 3'd1, 15'h0008);            // AL=9, RL=19
    check("R7 al max", al, 9);
    issue(C_RD, 3'd2, 15'h1000);
    check_read(19, 2, 4, "R8 max latency");

    // auto-precharge read
    issue(C_ACT, 3'd6, 15'h0077);
    issue(C_RD, 3'd2, 15'h1400);
    check("R4 auto precharge", bank_open, 8'h40);
    check_read(19, 2, 4, "R8 auto precharge read");
    issue(C_RD, 3'd2, 15'h1000);
    check("R5 closed read err", err, 1);
    check_read(0, 0, 0, "R5 no window");

    // masked read on open bank
    issue(4'b1101, 3'd6, 15'h1000);
    check("R1 masked read cmd", cmd, 0);
    check_read(0, 0, 0, "R1 masked read");

    // reset with a window pending
    issue(C_ACT, 3'd4, 15'h0042);
    issue(C_RD, 3'd4, 15'h1000);
    idle(3);
    rst_n = 1'b0;
    idle(1);
    check_reset_state("R10 mid reset");
    rst_n = 1'b1;
    check_read(0, 0, 0, "R10 pending cleared");
    issue(C_ACT, 3'd5, 15'h0005);
    issue(C_RD, 3'd5, 15'h0000);
    check_read(6, 4, 8, "R10 default burst");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule